// File: doc/BRIEF.md
# Self-Refreshing RAM Sleep-Mode Sequencer

This block sequences the low-power modes of a pseudo-static RAM that refreshes itself. It watches an asynchronous active-low sleep pin and a held sleep-select configuration bit. When the pin has stayed low long enough, the block either switches the memory off completely or keeps it in a retention mode with reduced refresh. The select bit makes the choice. Switching off loses the array contents and disables refresh entirely. Leaving the off state starts a long, timed wake-up window. Memory accesses stay blocked for the whole of that window.

All timing is counted on a free-running clock. The parameter `CYC_PER_US` gives the number of clock cycles per microsecond. The entry filter lasts `ENTRY_US` microseconds and the wake-up window lasts `WAKE_US` microseconds. The block drives the following outputs:
- the current mode;
- a refresh-enable signal for the refresh engine;
- an access grant that passes requests through only in normal operation;
- a sticky flag that reports lost contents until the host acknowledges it.

Top module: `psram_sleep_seq`

## Requirements
- R1: After reset the mode output is RUN. The mode encoding is RUN=0, RETAIN=1, OFF=2, WAKE=3. After reset `refresh_en` is 1, `data_invalid` is 0 and `acc_gnt` follows `acc_req`.
- R2: The pin passes through a two-stage synchronizer. A power-saving mode is entered only after the synchronized pin has been low for more than E = `CYC_PER_US*ENTRY_US` consecutive cycles. If the pin is driven low just after a clock edge and held low, the mode changes at the (E+3)th rising edge. A pin that is low for only E rising edges causes no mode change.
- R3: At entry, a select bit of 0 gives OFF and a select bit of 1 gives RETAIN. The select bit is the value stored from the last `cfg_wr` with `cfg_sel`.
- R4: `refresh_en` is 0 in OFF and 1 in every other mode.
- R5: Entering OFF sets `data_invalid`. The flag stays set through OFF and WAKE.
- R6: `acc_gnt` equals `acc_req` in RUN and is 0 in RETAIN, OFF and WAKE. A request that is refused is dropped and is not granted later.
- R7: When the pin returns high in OFF, the mode becomes WAKE at the third rising edge. WAKE lasts exactly W = `CYC_PER_US*WAKE_US` cycles, and then the mode is RUN. A pin low during WAKE does not change the mode.
- R8: A configuration write never causes the OFF mode. A write in RUN leaves the mode at RUN. Writing select=0 during RETAIN keeps the mode at RETAIN.
- R9: When the pin returns high in RETAIN, the mode becomes RUN at the third rising edge. `data_invalid` is not changed by this.
- R10: `data_invalid` clears only on reset or on `data_ack` while the mode is RUN. An acknowledge in OFF or WAKE is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_n | input | 1 | Asynchronous active-low sleep pin |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Sleep-select value stored on `cfg_wr` (1 = retain, 0 = off) |
| acc_req | input | 1 | Read or write request from the memory front end |
| data_ack | input | 1 | Host acknowledge of lost contents |
| mode | output | 2 | Current mode: 0 RUN, 1 RETAIN, 2 OFF, 3 WAKE |
| refresh_en | output | 1 | Enable for the refresh engine |
| acc_gnt | output | 1 | Access grant |
| data_invalid | output | 1 | Sticky flag: array contents are lost |

## Verification
The assertions take for granted that the select bit in force when an entry fires is the one written earlier. They also assume that the sleep pin reaches the design only through the synchronizer, so a pin change is seen two edges late. The stimulus drives every input just after a falling edge. It keeps configuration writes away from the cycle in which an entry can fire. It draws the random pulse lengths around the entry threshold so that both outcomes occur. After each random pulse it waits until the mode has returned to RUN and the flag has been acknowledged before the next trial starts, so the filter count always starts from zero.

// File: rtl/psram_sleep_pkg.sv
package psram_sleep_pkg;
   typedef enum logic [1:0] {
      MODE_RUN    = 2'd0,
      MODE_RETAIN = 2'd1,
      MODE_OFF    = 2'd2,
      MODE_WAKE   = 2'd3
   } pm_mode_e;
endpackage

// File: rtl/psram_pin_sync.sv
module psram_pin_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("psram_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], pin_async};
   end

   assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/psram_span_counter.sv
module psram_span_counter #(
   parameter int LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   output logic hit
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("psram_span_counter: LIMIT must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!(en && tick)) cnt_q <= '0;
      else if (cnt_q != LIM)  cnt_q <= cnt_q + CW'(1);
   end

   assign hit = en && tick && (cnt_q == LIM);

   // R2: a hit is only possible after the count ran in the previous cycle
   a_r2_hit_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(en && tick));
endmodule

// File: rtl/psram_sleep_seq.sv
module psram_sleep_seq
   import psram_sleep_pkg::*;
#(
   parameter int CYC_PER_US  = 125,
   parameter int ENTRY_US    = 10,
   parameter int WAKE_US     = 150,
   parameter int SYNC_STAGES = 2,
   parameter bit SEL_RESET   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_n,
   input  logic       cfg_wr,
   input  logic       cfg_sel,
   input  logic       acc_req,
   input  logic       data_ack,
   output logic [1:0] mode,
   output logic       refresh_en,
   output logic       acc_gnt,
   output logic       data_invalid
);
   localparam int ENTRY_CYC = CYC_PER_US * ENTRY_US;
   localparam int WAKE_CYC  = CYC_PER_US * WAKE_US;

   generate
      if (CYC_PER_US < 1) begin : g_bad_rate
         $error("psram_sleep_seq: CYC_PER_US must be at least 1");
      end
      if (WAKE_CYC < 2) begin : g_bad_wake
         $error("psram_sleep_seq: wake window must span at least 2 cycles");
      end
   endgenerate

   logic     pin_s, pin_low;
   logic     entry_hit, wake_done;
   logic     sel_q, inval_q;
   pm_mode_e mode_q, mode_d;

   psram_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(sleep_n), .pin_sync(pin_s));

   assign pin_low = !pin_s;

   psram_span_counter #(.LIMIT(ENTRY_CYC)) u_entry (
      .clk(clk), .rst_n(rst_n), .en(mode_q == MODE_RUN), .tick(pin_low),
      .hit(entry_hit));

   psram_span_counter #(.LIMIT(WAKE_CYC - 1)) u_wake (
      .clk(clk), .rst_n(rst_n), .en(mode_q == MODE_WAKE), .tick(1'b1),
      .hit(wake_done));

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= SEL_RESET;
      else if (cfg_wr) sel_q <= cfg_sel;
   end

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_RUN:    if (entry_hit) mode_d = sel_q ? MODE_RETAIN : MODE_OFF;
         MODE_RETAIN: if (!pin_low)  mode_d = MODE_RUN;
         MODE_OFF:    if (!pin_low)  mode_d = MODE_WAKE;
         MODE_WAKE:   if (wake_done) mode_d = MODE_RUN;
         default:     mode_d = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_RUN;
         inval_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (mode_q == MODE_RUN && entry_hit && !sel_q) inval_q <= 1'b1;
         else if (mode_q == MODE_RUN && data_ack)        inval_q <= 1'b0;
      end
   end

   assign mode         = mode_q;
   assign refresh_en   = (mode_q != MODE_OFF);
   assign acc_gnt      = acc_req && (mode_q == MODE_RUN);
   assign data_invalid = inval_q;

   // R3: the off state is reached from RUN only with the select bit clear
   a_r3_off_needs_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF && $past(mode_q) == MODE_RUN) |-> !$past(sel_q));

   // R5: contents are flagged as lost whenever the memory is off
   a_r5_off_marks_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |-> data_invalid);

   // R6: no grant is given outside RUN
   a_r6_gnt_only_run: assert property (@(posedge clk) disable iff (!rst_n)
      acc_gnt |-> (mode_q == MODE_RUN && acc_req));

   // R7: the wake window is only ever entered from OFF
   a_r7_wake_from_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_WAKE && $past(mode_q) != MODE_WAKE) |-> $past(mode_q) == MODE_OFF);

   // R8: retention never turns into off
   a_r8_retain_never_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) == MODE_RETAIN) |-> (mode_q != MODE_OFF));

   // R10: the flag falls only through an acknowledge in RUN
   a_r10_clear_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inval_q) |-> ($past(data_ack) && $past(mode_q) == MODE_RUN));
endmodule

// File: tb/sim_psram_sleep_seq.sv
module sim_psram_sleep_seq;
   localparam int CPU = 2;
   localparam int E   = CPU * 10;
   localparam int W   = CPU * 150;
   localparam int M_RUN = 0, M_RET = 1, M_OFF = 2, M_WAKE = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_n = 1'b1, cfg_wr = 1'b0, cfg_sel = 1'b0, acc_req = 1'b0, data_ack = 1'b0;
   logic [1:0] mode;
   logic refresh_en, acc_gnt, data_invalid;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   psram_sleep_seq #(.CYC_PER_US(CPU)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cfg_wr(cfg_wr),
      .cfg_sel(cfg_sel), .acc_req(acc_req), .data_ack(data_ack),
      .mode(mode), .refresh_en(refresh_en), .acc_gnt(acc_gnt),
      .data_invalid(data_invalid));

   function automatic int exp_gnt(int m, logic req);
      return (m == M_RUN && req) ? 1 : 0;
   endfunction

   function automatic int exp_refresh(int m);
      return (m == M_OFF) ? 0 : 1;
   endfunction

   function automatic int exp_entry_mode(int low_edges, logic sel);
      if (low_edges <= E) return M_RUN;
      return sel ? M_RET : M_OFF;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_outputs(string req, int m);
      check(req, int'(mode), m);
      check(req, int'(refresh_en), exp_refresh(m));
      check(req, int'(acc_gnt), exp_gnt(m, acc_req));
   endtask

   task automatic write_sel(logic v);
      cfg_sel = v; cfg_wr = 1'b1; step(1); cfg_wr = 1'b0;
   endtask

   task automatic ack_pulse();
      data_ack = 1'b1; step(1); data_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int n;
      int l;
      logic s;
      int em;
      void'($urandom(32'd1205));
      step(3);
      rst_n = 1'b1;
      acc_req = 1'b1;
      step(1);
      // R1 reset state
      check_outputs("R1", M_RUN);
      check("R1", int'(data_invalid), 0);
      acc_req = 1'b0; step(1);
      check("R1", int'(acc_gnt), 0);

      // R8: writes in RUN never change the mode
      write_sel(1'b0); write_sel(1'b1); write_sel(1'b0);
      step(2);
      check("R8", int'(mode), M_RUN);
      check("R8", int'(data_invalid), 0);

      // R2: exactly E low edges, no entry
      sleep_n = 1'b0; step(E); sleep_n = 1'b1; step(3);
      check("R2", int'(mode), M_RUN);
      step(3);

      // R2/R3/R4/R5/R6: held low, entry exactly at edge E+3, select clear -> OFF
      acc_req = 1'b1;
      sleep_n = 1'b0; step(E + 2);
      check("R2", int'(mode), M_RUN);
      step(1);
      check("R2", int'(mode), M_OFF);
      check_outputs("R4", M_OFF);
      check("R5", int'(data_invalid), 1);
      // R10: acknowledge while off is ignored
      ack_pulse();
      check("R10", int'(data_invalid), 1);
      check("R6", int'(acc_gnt), 0);

      // R7: exit into the wake window; pin low inside the window is ignored
      sleep_n = 1'b1; step(2);
      check("R7", int'(mode), M_OFF);
      step(1);
      check("R7", int'(mode), M_WAKE);
      n = 0;
      while (mode == 2'(M_WAKE) && n < W + 10) begin
         if (n == 10) sleep_n = 1'b0;
         if (n == 16) sleep_n = 1'b1;
         if (n == 20) begin
            data_ack = 1'b1;
            check("R6", int'(acc_gnt), 0);
         end
         if (n == 21) begin
            data_ack = 1'b0;
            check("R10", int'(data_invalid), 1);
         end
         n++;
         step(1);
      end
      check("R7", n, W);
      check_outputs("R7", M_RUN);
      check("R5", int'(data_invalid), 1);
      ack_pulse();
      check("R10", int'(data_invalid), 0);

      // R8/R9: retention entry, a write of select=0 keeps RETAIN
      write_sel(1'b1);
      step(2);
      sleep_n = 1'b0; step(E + 3);
      check("R3", int'(mode), M_RET);
      check_outputs("R6", M_RET);
      write_sel(1'b0);
      step(3);
      check("R8", int'(mode), M_RET);
      check("R8", int'(refresh_en), 1);
      sleep_n = 1'b1; step(2);
      check("R9", int'(mode), M_RET);
      step(1);
      check("R9", int'(mode), M_RUN);
      check("R9", int'(data_invalid), 0);
      step(3);

      // random trials around the threshold
      for (int t = 0; t < 40; t++) begin
         l = E - 2 + int'($urandom_range(0, 5));
         s = 1'(($urandom_range(0, 1)));
         write_sel(s);
         step(2);
         sleep_n = 1'b0;
         for (int k = 0; k < l; k++) begin
            acc_req = 1'(($urandom_range(0, 1)));
            step(1);
         end
         sleep_n = 1'b1;
         step(2);
         em = exp_entry_mode(l, s);
         check("R2", int'(mode), em);
         check_outputs("R3", em);
         if (em == M_OFF) begin
            check("R5", int'(data_invalid), 1);
            step(1);
            check("R7", int'(mode), M_WAKE);
            n = 0;
            while (mode == 2'(M_WAKE) && n < W + 10) begin
               n++;
               step(1);
            end
            check("R7", n, W);
            ack_pulse();
            check("R10", int'(data_invalid), 0);
         end else if (em == M_RET) begin
            step(1);
            check("R9", int'(mode), M_RUN);
            check("R9", int'(data_invalid), 0);
         end else begin
            step(1);
            check("R2", int'(mode), M_RUN);
         end
         step(3);
      end
      finish_run();
   end
endmodule